// File: doc/BRIEF.md
# SPI Master Controller

This block is a serial peripheral interface master clocked from the system clock. A set of static configuration inputs selects the idle level of the serial clock, the edge on which data is sampled, a power-of-two rate divider, a short or long frame, the order in which bits leave and arrive, an enable, and a receive-only mode. A host writes words into a one-entry transmit holding register and reads received words from a one-entry receive holding register. Four status flags report activity, transmit space, received data and lost data.

Every serial clock cycle moves one bit out on the data output and one bit in from the data input at the same time. Whenever a new word is waiting when a frame ends, the next frame follows with no idle time, so a host that refills the transmit register promptly gets a continuous stream. The slave-select output is driven straight from a host input through one register, so it can stay low across any number of frames.

Top module: `spi_master_ctrl`

## Requirements
- R1: After reset, `st_txe` is 1, `st_busy`, `st_rxne` and `st_ovr` are 0, `host_rdata` is 0, `spi_sclk` is 0 and `spi_cs_n` is 1.
- R2: With rate code `cfg_rate` = k, one serial clock period lasts 2^(k+1) system clock cycles (k from 0 to 7, so /2 to /256).
- R3: While no frame is running, `spi_sclk` rests at `cfg_cpol` (0 rests low, 1 rests high).
- R4: With `cfg_cpha` = 0 data is sampled on the 1st, 3rd, ... serial clock edges of a frame and changed on the others; with `cfg_cpha` = 1 it is sampled on the 2nd, 4th, ... edges. In all four polarity/phase combinations both directions carry the correct word in every frame.
- R5: `cfg_wide` = 0 gives 8-bit frames using `host_wdata[7:0]` and returning the word in `host_rdata[7:0]` with the upper byte 0; `cfg_wide` = 1 gives 16-bit frames.
- R6: `cfg_lsb_first` = 0 puts the most significant bit of the frame on the wire first; 1 puts bit 0 first. Received words are assembled with the same order.
- R7: A `host_wr` pulse clears `st_txe`; `st_txe` returns to 1 in the cycle after the word is moved into the shifter at frame start.
- R8: `st_rxne` rises after a frame completes and a `host_rd` pulse clears it in the next cycle.
- R9: When a frame completes while `st_rxne` is 1 and no read occurs in that cycle, `st_ovr` becomes 1 and `host_rdata` keeps the older word. `st_ovr` clears only on a `host_rd` that follows a `host_stat_rd` seen while `st_ovr` was 1.
- R10: `st_busy` is 1 whenever a frame is shifting or the transmit register holds a word.
- R11: When a new word is written before the current frame ends, the next frame starts with no gap: leading edge N of the stream comes exactly N frame-bit periods after the first one.
- R12: With `cfg_rx_only` = 1, frames run while enabled without needing a written word, `spi_mosi` stays 0, and the transmit register is neither consumed nor altered.
- R13: With `cfg_en` = 0 no frame starts and `spi_sclk` does not move, even with a word waiting; a frame already running finishes.
- R14: `spi_cs_n` equals the inverse of `cs_assert` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Allows new frames to start |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sample on even edges when 1, odd edges when 0 |
| cfg_rate | input | RATE_W | Divider code k, period 2^(k+1) cycles |
| cfg_wide | input | 1 | 16-bit frames when 1, 8-bit when 0 |
| cfg_lsb_first | input | 1 | Bit 0 first on the wire when 1 |
| cfg_rx_only | input | 1 | Clock in only, output held low |
| cs_assert | input | 1 | Host request to select the slave |
| host_wr | input | 1 | Write pulse for the transmit register |
| host_wdata | input | DATA_W | Word to transmit |
| host_rd | input | 1 | Read pulse for the receive register |
| host_rdata | output | DATA_W | Last accepted received word |
| host_stat_rd | input | 1 | Status read pulse, arms overrun clearing |
| st_busy | output | 1 | Frame shifting or word waiting |
| st_txe | output | 1 | Transmit register empty |
| st_rxne | output | 1 | Received word waiting |
| st_ovr | output | 1 | Received word lost |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low slave select |

## Verification
The main function is swept over all sixteen combinations of polarity, phase, frame width and bit order, each with two back-to-back frames whose data words are formed arithmetically from the combination index, so a wrong sampling edge, a swapped order or a truncated width each corrupts a different bit pattern in one direction or the other. A second sweep steps the rate code through all eight values and measures edge spacing, separating a divider off by one power of two from a gap between frames. Directed sequences then hold a word with the enable low, overfill the receive register, and run receive-only frames while a word sits in the transmit register, so that consumed, lost or leaked data shows up at the ports.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic {
    ENG_IDLE  = 1'b0,
    ENG_SHIFT = 1'b1
  } eng_state_e;

  typedef struct packed {
    logic en;
    logic cpol;
    logic cpha;
    logic wide;
    logic lsb;
    logic rx_only;
  } spim_cfg_t;

endpackage

// File: rtl/spim_rate_gen.sv
module spim_rate_gen #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int CNT_W = (1 << RATE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb lim = CNT_W'((32'd1 << rate) - 32'd1);

  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run || restart || tick) cnt <= '0;
    else                                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spim_shift_eng.sv
module spim_shift_eng
  import spim_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  spim_cfg_t         cfg,
  input  logic              tx_full,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tick,
  input  logic              miso,
  output logic              run,
  output logic              start,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              sclk,
  output logic              mosi
);
  localparam int HALF_W = DATA_W / 2;
  localparam int EDGE_W = $clog2(2 * DATA_W);
  localparam logic [EDGE_W-1:0] LAST_LONG  = EDGE_W'(2 * DATA_W - 1);
  localparam logic [EDGE_W-1:0] LAST_SHORT = EDGE_W'(DATA_W - 1);

  eng_state_e        state;
  logic [EDGE_W-1:0] edge_cnt;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] rx_sh;
  logic [DATA_W-1:0] rx_next;
  logic [DATA_W-1:0] load_word;
  logic [DATA_W-1:0] load_sh;
  logic [EDGE_W-1:0] last_edge;
  logic              can_go;
  logic              at_last;
  logic              sample_now;
  logic              shift_now;

  // Bring a word into wire order (or back): optional reversal, short
  // frames kept in the low half.
  function automatic logic [DATA_W-1:0] arrange(input logic [DATA_W-1:0] d,
                                                input logic wide,
                                                input logic lsb);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = d[DATA_W-1-i];
    if (!lsb) return wide ? d : {{HALF_W{1'b0}}, d[HALF_W-1:0]};
    return wide ? r : {{HALF_W{1'b0}}, r[DATA_W-1:HALF_W]};
  endfunction

  assign last_edge  = cfg.wide ? LAST_LONG : LAST_SHORT;
  assign run        = (state == ENG_SHIFT);
  assign can_go     = cfg.en && (cfg.rx_only || tx_full);
  assign at_last    = run && tick && (edge_cnt == last_edge);
  assign start      = can_go && ((state == ENG_IDLE) || at_last);
  assign sample_now = run && tick && (edge_cnt[0] == cfg.cpha);
  assign shift_now  = run && tick && (edge_cnt[0] != cfg.cpha);
  assign rx_next    = sample_now ? {rx_sh[DATA_W-2:0], miso} : rx_sh;
  assign load_word  = arrange(tx_word, cfg.wide, cfg.lsb);
  assign load_sh    = cfg.wide ? load_word : (load_word << HALF_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ENG_IDLE;
      edge_cnt <= '0;
      sh       <= '0;
      rx_sh    <= '0;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      done     <= 1'b0;
      rx_word  <= '0;
    end else begin
      done  <= at_last;
      rx_sh <= rx_next;
      if (at_last) rx_word <= arrange(rx_next, cfg.wide, cfg.lsb);

      if (start) begin
        state    <= ENG_SHIFT;
        edge_cnt <= '0;
        sclk     <= at_last ? ~sclk : cfg.cpol;
        if (!cfg.cpha) begin
          mosi <= load_sh[DATA_W-1];
          sh   <= load_sh << 1;
        end else begin
          sh   <= load_sh;
        end
      end else if (at_last) begin
        state <= ENG_IDLE;
        sclk  <= ~sclk;
      end else if (state == ENG_IDLE) begin
        sclk <= cfg.cpol;
      end else if (tick) begin
        sclk     <= ~sclk;
        edge_cnt <= edge_cnt + 1'b1;
        if (shift_now) begin
          mosi <= sh[DATA_W-1];
          sh   <= sh << 1;
        end
      end

      if (cfg.rx_only) mosi <= 1'b0;
    end
  end
endmodule

// File: rtl/spim_host_regs.sv
module spim_host_regs #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  input  logic              stat_rd,
  input  logic              pop,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              run,
  output logic              tx_full,
  output logic [DATA_W-1:0] tx_word,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              txe,
  output logic              rxne,
  output logic              ovr
);
  logic ovr_armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_full   <= 1'b0;
      tx_word   <= '0;
      rdata     <= '0;
      rxne      <= 1'b0;
      ovr       <= 1'b0;
      ovr_armed <= 1'b0;
    end else begin
      if (wr) begin
        tx_word <= wdata;
        tx_full <= 1'b1;
      end else if (pop) begin
        tx_full <= 1'b0;
      end

      if (stat_rd && ovr) ovr_armed <= 1'b1;

      if (rd) begin
        rxne <= 1'b0;
        if (ovr_armed) begin
          ovr       <= 1'b0;
          ovr_armed <= 1'b0;
        end
      end

      if (done) begin
        if (rxne && !rd) begin
          ovr <= 1'b1;
        end else begin
          rdata <= rx_word;
          rxne  <= 1'b1;
        end
      end
    end
  end

  assign busy = run || tx_full;
  assign txe  = !tx_full;
endmodule

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl
  import spim_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_wide,
  input  logic              cfg_lsb_first,
  input  logic              cfg_rx_only,
  input  logic              cs_assert,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              host_stat_rd,
  output logic              st_busy,
  output logic              st_txe,
  output logic              st_rxne,
  output logic              st_ovr,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  spim_cfg_t         cfg;
  logic              tick;
  logic              run;
  logic              start;
  logic              frame_done;
  logic [DATA_W-1:0] rx_word;
  logic              tx_full;
  logic [DATA_W-1:0] tx_word;
  logic              pop;

  assign cfg = '{en: cfg_en, cpol: cfg_cpol, cpha: cfg_cpha,
                 wide: cfg_wide, lsb: cfg_lsb_first, rx_only: cfg_rx_only};
  assign pop = start && !cfg_rx_only;

  spim_rate_gen #(.RATE_W(RATE_W)) u_rate (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .restart (start),
    .rate    (cfg_rate),
    .tick    (tick)
  );

  spim_shift_eng #(.DATA_W(DATA_W)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg),
    .tx_full (tx_full),
    .tx_word (tx_word),
    .tick    (tick),
    .miso    (spi_miso),
    .run     (run),
    .start   (start),
    .done    (frame_done),
    .rx_word (rx_word),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi)
  );

  spim_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (host_wr),
    .wdata   (host_wdata),
    .rd      (host_rd),
    .stat_rd (host_stat_rd),
    .pop     (pop),
    .done    (frame_done),
    .rx_word (rx_word),
    .run     (run),
    .tx_full (tx_full),
    .tx_word (tx_word),
    .rdata   (host_rdata),
    .busy    (st_busy),
    .txe     (st_txe),
    .rxne    (st_rxne),
    .ovr     (st_ovr)
  );

  always_ff @(posedge clk) begin
    if (rst) spi_cs_n <= 1'b1;
    else     spi_cs_n <= ~cs_assert;
  end
endmodule

// File: rtl/spi_master_ctrl_chk.sv
module spi_master_ctrl_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_cpol,
  input logic              cfg_rx_only,
  input logic              cs_assert,
  input logic              host_rd,
  input logic [DATA_W-1:0] host_rdata,
  input logic              st_busy,
  input logic              st_txe,
  input logic              st_rxne,
  input logic              st_ovr,
  input logic              spi_sclk,
  input logic              spi_mosi,
  input logic              spi_cs_n,
  input logic              frame_done
);
  a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!st_busy && $past(!st_busy) && $past(!rst) && $stable(cfg_cpol))
      |-> (spi_sclk == cfg_cpol));

  a_r10_waiting_word_busy: assert property (@(posedge clk) disable iff (rst)
    !st_txe |-> st_busy);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !frame_done) |=> !st_rxne);

  a_r9_ovr_sets: assert property (@(posedge clk) disable iff (rst)
    (frame_done && st_rxne && !host_rd) |=> st_ovr);

  a_r9_old_word_kept: assert property (@(posedge clk) disable iff (rst)
    (frame_done && st_rxne && !host_rd) |=> $stable(host_rdata));

  a_r12_rx_only_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_rx_only) |-> !spi_mosi);

  a_r14_cs_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (spi_cs_n == !$past(cs_assert)));
endmodule

bind spi_master_ctrl spi_master_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_cpol    (cfg_cpol),
  .cfg_rx_only (cfg_rx_only),
  .cs_assert   (cs_assert),
  .host_rd     (host_rd),
  .host_rdata  (host_rdata),
  .st_busy     (st_busy),
  .st_txe      (st_txe),
  .st_rxne     (st_rxne),
  .st_ovr      (st_ovr),
  .spi_sclk    (spi_sclk),
  .spi_mosi    (spi_mosi),
  .spi_cs_n    (spi_cs_n),
  .frame_done  (frame_done)
);

// File: tb/tb_spi_master_ctrl.sv
module tb_spi_master_ctrl;
  localparam int DW = 16;
  localparam int RW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          cfg_en = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [RW-1:0] cfg_rate = '0;
  logic          cfg_wide = 1'b0, cfg_lsb_first = 1'b0, cfg_rx_only = 1'b0;
  logic          cs_assert = 1'b0;
  logic          host_wr = 1'b0, host_rd = 1'b0, host_stat_rd = 1'b0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          st_busy, st_txe, st_rxne, st_ovr;
  logic          spi_sclk, spi_mosi, spi_miso, spi_cs_n;

  spi_master_ctrl #(.DATA_W(DW), .RATE_W(RW)) dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_rate(cfg_rate), .cfg_wide(cfg_wide),
    .cfg_lsb_first(cfg_lsb_first), .cfg_rx_only(cfg_rx_only),
    .cs_assert(cs_assert), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .host_stat_rd(host_stat_rd),
    .st_busy(st_busy), .st_txe(st_txe), .st_rxne(st_rxne), .st_ovr(st_ovr),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  logic [63:0] sl_stream = '0;
  int          sl_gen = 0;
  int          sl_seen = 0;
  int          sl_k = 0;
  logic [63:0] sl_got = '0;
  int          sl_n = 0;
  int          lead_t [0:63];
  int          lead_n = 0;
  logic        sl_prev = 1'b0;
  logic        sl_lead;

  assign spi_miso = (sl_k >= 0 && sl_k < 64) ? sl_stream[63-sl_k] : 1'b0;

  always @(spi_sclk, sl_gen) begin
    if (sl_gen != sl_seen) begin
      sl_seen = sl_gen;
      sl_k    = cfg_cpha ? -1 : 0;
      sl_n    = 0;
      lead_n  = 0;
      sl_got  = '0;
      sl_prev = spi_sclk;
    end else if (spi_sclk != sl_prev) begin
      sl_prev = spi_sclk;
      sl_lead = (spi_sclk != cfg_cpol);
      if (sl_lead && lead_n < 64) begin
        lead_t[lead_n] = cyc;
        lead_n++;
      end
      if (sl_lead ^ cfg_cpha) begin
        if (sl_n < 64) sl_got[63-sl_n] = spi_mosi;
        sl_n++;
      end else begin
        sl_k++;
      end
    end
  end

  function automatic logic [63:0] pack2(input logic [15:0] a, input logic [15:0] b,
                                        input logic wide, input logic lsb);
    logic [63:0] s = '0;
    int n = wide ? 16 : 8;
    for (int i = 0; i < n; i++) begin
      s[63-i]   = lsb ? a[i] : a[n-1-i];
      s[63-n-i] = lsb ? b[i] : b[n-1-i];
    end
    return s;
  endfunction

  function automatic logic [15:0] unpack(input logic [63:0] g, input int off,
                                         input logic wide, input logic lsb);
    logic [15:0] w = '0;
    int n = wide ? 16 : 8;
    for (int i = 0; i < n; i++) begin
      if (lsb) w[i] = g[63-off-i];
      else     w[n-1-i] = g[63-off-i];
    end
    return w;
  endfunction

  // ---------------- host helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_word(input logic [15:0] w);
    host_wr = 1'b1; host_wdata = w;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic pulse_stat();
    host_stat_rd = 1'b1;
    @(negedge clk);
    host_stat_rd = 1'b0;
  endtask

  task automatic wait_rxne();
    while (!st_rxne) @(negedge clk);
  endtask

  task automatic set_cfg(input logic cpol, input logic cpha, input logic wide,
                         input logic lsb, input logic [RW-1:0] br);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_wide = wide;
    cfg_lsb_first = lsb; cfg_rate = br;
  endtask

  task automatic restart_slave(input logic [63:0] stream);
    sl_stream = stream;
    sl_gen++;
    tick(1);
  endtask

  // Two back-to-back frames in one configuration.
  task automatic run_pair(input int idx, input logic cpol, input logic cpha,
                          input logic wide, input logic lsb, input logic [RW-1:0] br);
    logic [15:0] mask, w0, w1, s0, s1;
    int n   = wide ? 16 : 8;
    int per = 1 << (int'(br) + 1);
    mask = wide ? 16'hFFFF : 16'h00FF;
    w0 = 16'(16'h5A3C + idx * 16'h1357) & mask;
    w1 = 16'(16'hC3A5 ^ (idx * 16'h0F1E)) & mask;
    s0 = 16'(16'h9B61 + idx * 16'h2468) & mask;
    s1 = 16'(16'h4E27 ^ (idx * 16'h3141)) & mask;

    cfg_en = 1'b0;
    set_cfg(cpol, cpha, wide, lsb, br);
    tick(3);
    check("R3", "idle sclk level", 32'(spi_sclk), 32'(cpol));
    restart_slave(pack2(s0, s1, wide, lsb));

    write_word(w0);
    cfg_en = 1'b1;
    while (!st_txe) @(negedge clk);
    check("R10", "busy while shifting", 32'(st_busy), 32'd1);
    write_word(w1);

    wait_rxne();
    check("R4 R5 R6", $sformatf("first word rx cfg %0d", idx), 32'(host_rdata), 32'(s0));
    pulse_rd();
    wait_rxne();
    check("R4 R5 R6", $sformatf("second word rx cfg %0d", idx), 32'(host_rdata), 32'(s1));
    pulse_rd();
    cfg_en = 1'b0;
    while (st_busy) @(negedge clk);
    tick(3);
    check("R8", "rxne cleared by read", 32'(st_rxne), 32'd0);
    check("R4 R5 R6", $sformatf("first word tx cfg %0d", idx),
          32'(unpack(sl_got, 0, wide, lsb)), 32'(w0));
    check("R4 R5 R6", $sformatf("second word tx cfg %0d", idx),
          32'(unpack(sl_got, n, wide, lsb)), 32'(w1));
    check("R2", $sformatf("sclk period rate %0d", br),
          32'(lead_t[1] - lead_t[0]), 32'(per));
    check("R11", "no gap between frames",
          32'(lead_t[n] - lead_t[0]), 32'(n * per));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..all: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    tick(5);
    rst = 1'b0;
    tick(1);
    check("R1", "txe after reset",  32'(st_txe),  32'd1);
    check("R1", "busy after reset", 32'(st_busy), 32'd0);
    check("R1", "rxne after reset", 32'(st_rxne), 32'd0);
    check("R1", "ovr after reset",  32'(st_ovr),  32'd0);
    check("R1", "rdata after reset", 32'(host_rdata), 32'd0);
    check("R1", "sclk after reset", 32'(spi_sclk), 32'd0);
    check("R1", "cs_n after reset", 32'(spi_cs_n), 32'd1);

    // R14 slave select
    cs_assert = 1'b1;
    tick(1);
    check("R14", "cs_n low after assert", 32'(spi_cs_n), 32'd0);
    cs_assert = 1'b0;
    tick(1);
    check("R14", "cs_n high after release", 32'(spi_cs_n), 32'd1);
    cs_assert = 1'b1;

    // Sweep of polarity, phase, width, order
    for (int c = 0; c < 16; c++)
      run_pair(c, c[0], c[1], c[2], c[3], 3'd1);

    // Sweep of rate codes
    for (int b = 0; b < 8; b++)
      run_pair(16 + b, b[0], b[1], (b >= 4), b[1] ^ b[0], RW'(b));

    // R13 / R7 enable gating
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 3'd0);
    cfg_en = 1'b0;
    tick(2);
    restart_slave(pack2(16'h0055, 16'h0000, 1'b0, 1'b0));
    write_word(16'h00C6);
    check("R7", "txe cleared by write", 32'(st_txe), 32'd0);
    tick(40);
    check("R13", "no edges while disabled", 32'(lead_n), 32'd0);
    check("R13", "sclk idle while disabled", 32'(spi_sclk), 32'd0);
    check("R10", "busy with word waiting", 32'(st_busy), 32'd1);
    cfg_en = 1'b1;
    while (!st_txe) @(negedge clk);
    check("R7", "txe set after frame start", 32'(st_txe), 32'd1);
    cfg_en = 1'b0;
    wait_rxne();
    check("R13", "frame runs once enabled", 32'(host_rdata), 32'h0055);
    pulse_rd();
    while (st_busy) @(negedge clk);
    tick(2);
    check("R13", "word sent once enabled", 32'(unpack(sl_got, 0, 1'b0, 1'b0)), 32'h00C6);

    // R9 overrun
    restart_slave(pack2(16'h0011, 16'h0022, 1'b0, 1'b0));
    write_word(16'h00A1);
    cfg_en = 1'b1;
    while (!st_txe) @(negedge clk);
    write_word(16'h00B2);
    tick(2);
    while (st_busy) @(negedge clk);
    cfg_en = 1'b0;
    tick(3);
    check("R9", "rxne held on overrun", 32'(st_rxne), 32'd1);
    check("R9", "ovr set", 32'(st_ovr), 32'd1);
    check("R9", "older word kept", 32'(host_rdata), 32'h0011);
    pulse_rd();
    tick(1);
    check("R8", "rxne cleared by read", 32'(st_rxne), 32'd0);
    check("R9", "ovr kept by bare read", 32'(st_ovr), 32'd1);
    pulse_stat();
    pulse_rd();
    tick(1);
    check("R9", "ovr cleared by status then data read", 32'(st_ovr), 32'd0);

    // R12 receive only
    restart_slave(pack2(16'h003D, 16'h0081, 1'b0, 1'b0));
    write_word(16'h00F0);
    cfg_rx_only = 1'b1;
    tick(1);
    cfg_en = 1'b1;
    wait_rxne();
    check("R12", "receive-only first word", 32'(host_rdata), 32'h003D);
    pulse_rd();
    cfg_en = 1'b0;
    tick(60);
    check("R12", "receive-only second word", 32'(host_rdata), 32'h0081);
    check("R12", "transmit word not consumed", 32'(st_txe), 32'd0);
    check("R12", "frames clocked", 32'(sl_n >= 8), 32'd1);
    check("R12", "mosi held low", 32'(sl_got[63:48]), 32'd0);
    pulse_rd();
    cfg_rx_only = 1'b0;
    tick(1);
    restart_slave(pack2(16'h0000, 16'h0000, 1'b0, 1'b0));
    cfg_en = 1'b1;
    while (!st_txe) @(negedge clk);
    cfg_en = 1'b0;
    while (st_busy) @(negedge clk);
    tick(3);
    check("R12", "held word sent afterwards", 32'(unpack(sl_got, 0, 1'b0, 1'b0)), 32'h00F0);
    pulse_rd();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule